// File: doc/BRIEF.md
# SPI queue status flag register

This block keeps the sticky status flags of a queued SPI controller. Single-cycle event strobes arrive from the shift engine and the FIFO logic. They report that the final receive bit of a frame was sampled, that the executing command closes the queue, that a transfer has begun, the fill state of the transmit and receive FIFOs, the receive shift register, and DMA acknowledges. The block turns these into flags that software reads in one 32-bit status word and clears by writing 1 to the bit.

The block also holds the running/stopped state of the controller. Start and stop strobes from the control logic move that state. When the end-of-queue flag sets, the controller is forced to the stopped state on the same clock edge. The status word is read combinationally from the flag registers. A write takes effect on the next rising clock edge.

Top module: `spi_qstat_reg`

## Requirements
- R1: While rst_ni is low, rd_data_o and running_o are 0.
- R2: The transfer-done flag (bit 0) is set on the edge after last_bit_i is high, and is cleared by a write with data bit 0 at 1.
- R3: The queue-end flag (bit 3) is set on the edge after last_bit_i and eoq_cmd_i are both high while slave_mode_i is low. It never sets while slave_mode_i is high. A write of 1 to bit 3 clears it.
- R4: On the edge where the queue-end flag is set, the running state goes to 0, even if start_i is high in the same cycle.
- R5: Without a queue-end set, stop_i clears the running state and start_i sets it, with stop_i winning when both are high. The running state reads at bit 1 and on running_o, and writes to bit 1 have no effect.
- R6: The TX underflow flag (bit 4) is set when xfer_start_i, slave_mode_i and txf_empty_i are all high. A write of 1 to bit 4 clears it.
- R7: The TX room flag (bit 6) is set on every edge where txf_full_i is low. While txf_full_i is high, it is cleared by a write of 1 to bit 6 or by dma_ack_i. A dma_ack_i while txf_full_i is low leaves it at 1.
- R8: The RX overflow flag (bit 12) is set when xfer_start_i, rxf_full_i and shreg_full_i are all high. A write of 1 to bit 12 clears it.
- R9: If a set condition and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R10: Bits 2, 5, 7 to 11 and 13 to 31 always read 0, whatever is written to them.
- R11: A flag holds its value when no set condition and no clear reaches it. Writing 0 to a flag bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Status word write strobe |
| wr_data_i | input | 32 | Write data, 1 clears the flag at that bit |
| rd_data_o | output | 32 | Status word |
| last_bit_i | input | 1 | Final receive bit of a frame sampled |
| eoq_cmd_i | input | 1 | Executing command marks the end of the queue |
| slave_mode_i | input | 1 | Controller operates as SPI slave |
| xfer_start_i | input | 1 | A transfer is being initiated |
| txf_full_i | input | 1 | Transmit FIFO full |
| txf_empty_i | input | 1 | Transmit FIFO empty |
| rxf_full_i | input | 1 | Receive FIFO full |
| shreg_full_i | input | 1 | Receive shift register holds unread data |
| dma_ack_i | input | 1 | DMA acknowledge for a transmit fill request |
| start_i | input | 1 | Request to enter the running state |
| stop_i | input | 1 | Request to enter the stopped state |
| running_o | output | 1 | Running state |

## Verification
The hardest situation to reach is the one where several rules meet in one cycle. Examples are a queue-end set together with a start and a write, or a DMA acknowledge against a full FIFO while a write-1 arrives. These collisions decide the priority behaviour. The bench sweeps every combination of the eleven event inputs, each with and without a write strobe, and draws the write data from an LFSR. This drives every collision from a running history of flag states. The bench compares each field against its own model after every edge.

// File: rtl/spi_qstat_pkg.sv
package spi_qstat_pkg;
  localparam int unsigned STAT_W   = 32;
  localparam int unsigned NUM_FLAG = 5;

  // bit positions in the status word
  localparam int unsigned TCF_BIT  = 0;
  localparam int unsigned RUN_BIT  = 1;
  localparam int unsigned EOQ_BIT  = 3;
  localparam int unsigned TFUF_BIT = 4;
  localparam int unsigned TFFF_BIT = 6;
  localparam int unsigned RFOF_BIT = 12;

  // flag vector index
  typedef enum logic [2:0] {
    F_TCF  = 3'd0,
    F_EOQ  = 3'd1,
    F_TFUF = 3'd2,
    F_TFFF = 3'd3,
    F_RFOF = 3'd4
  } flag_idx_e;

  typedef struct packed {
    logic last_bit;
    logic eoq_cmd;
    logic slave_mode;
    logic xfer_start;
    logic txf_full;
    logic txf_empty;
    logic rxf_full;
    logic shreg_full;
    logic dma_ack;
  } evt_t;

  function automatic int unsigned flag_pos(input int unsigned idx);
    case (idx)
      0:       flag_pos = TCF_BIT;
      1:       flag_pos = EOQ_BIT;
      2:       flag_pos = TFUF_BIT;
      3:       flag_pos = TFFF_BIT;
      default: flag_pos = RFOF_BIT;
    endcase
  endfunction

  function automatic logic [STAT_W-1:0] live_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_FLAG; i++) m[flag_pos(i)] = 1'b1;
    m[RUN_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/spi_qstat_evt.sv
module spi_qstat_evt
  import spi_qstat_pkg::*;
#(
  parameter int unsigned NF = NUM_FLAG,
  parameter int unsigned W  = STAT_W
) (
  input  evt_t           evt_i,
  input  logic           wr_en_i,
  input  logic [W-1:0]   wr_data_i,
  output logic [NF-1:0]  set_o,
  output logic [NF-1:0]  clr_o,
  output logic           eoq_hit_o
);
  logic [NF-1:0] w1c;

  for (genvar g = 0; g < NF; g++) begin : g_w1c
    assign w1c[g] = wr_en_i & wr_data_i[flag_pos(g)];
  end

  assign eoq_hit_o = evt_i.last_bit & evt_i.eoq_cmd & ~evt_i.slave_mode;

  always_comb begin
    set_o = '0;
    clr_o = w1c;
    set_o[F_TCF]  = evt_i.last_bit;
    set_o[F_EOQ]  = eoq_hit_o;
    set_o[F_TFUF] = evt_i.xfer_start & evt_i.slave_mode & evt_i.txf_empty;
    set_o[F_RFOF] = evt_i.xfer_start & evt_i.rxf_full & evt_i.shreg_full;
    // room flag: level set while not full; DMA ack only clears when full
    set_o[F_TFFF] = ~evt_i.txf_full;
    clr_o[F_TFFF] = w1c[F_TFFF] | (evt_i.dma_ack & evt_i.txf_full);
  end
endmodule

// File: rtl/spi_qstat_flag.sv
module spi_qstat_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= RST_VAL;
    else if (set_i) q_q <= 1'b1;
    else if (clr_i) q_q <= 1'b0;
  end

  assign q_o = q_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o); // R9
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> (q_o == $past(q_o))); // R11
endmodule

// File: rtl/spi_qstat_run.sv
module spi_qstat_run (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eoq_hit_i,
  input  logic start_i,
  input  logic stop_i,
  output logic run_o
);
  logic run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= 1'b0;
    else if (eoq_hit_i || stop_i) run_q <= 1'b0;
    else if (start_i)             run_q <= 1'b1;
  end

  assign run_o = run_q;

  AST_EOQ_BEATS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoq_hit_i |=> !run_o); // R4
  AST_STOP_BEATS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_o); // R5
  AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && !eoq_hit_i) |=> run_o); // R5
endmodule

// File: rtl/spi_qstat_reg.sv
module spi_qstat_reg
  import spi_qstat_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] rd_data_o,
  input  logic         last_bit_i,
  input  logic         eoq_cmd_i,
  input  logic         slave_mode_i,
  input  logic         xfer_start_i,
  input  logic         txf_full_i,
  input  logic         txf_empty_i,
  input  logic         rxf_full_i,
  input  logic         shreg_full_i,
  input  logic         dma_ack_i,
  input  logic         start_i,
  input  logic         stop_i,
  output logic         running_o
);
  localparam int unsigned NF = NUM_FLAG;
  localparam logic [W-1:0] LIVE = W'(live_mask());

  evt_t          evt;
  logic [NF-1:0] set_v, clr_v, flag_q;
  logic          eoq_hit, run;

  assign evt = '{last_bit: last_bit_i, eoq_cmd: eoq_cmd_i,
                 slave_mode: slave_mode_i, xfer_start: xfer_start_i,
                 txf_full: txf_full_i, txf_empty: txf_empty_i,
                 rxf_full: rxf_full_i, shreg_full: shreg_full_i,
                 dma_ack: dma_ack_i};

  spi_qstat_evt #(.NF(NF), .W(W)) u_evt (
    .evt_i     (evt),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .set_o     (set_v),
    .clr_o     (clr_v),
    .eoq_hit_o (eoq_hit)
  );

  for (genvar g = 0; g < NF; g++) begin : g_flag
    spi_qstat_flag #(.RST_VAL(1'b0)) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .q_o    (flag_q[g])
    );
  end

  spi_qstat_run u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eoq_hit_i (eoq_hit),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .run_o     (run)
  );

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NF; i++) rd_data_o[flag_pos(i)] = flag_q[i];
    rd_data_o[RUN_BIT] = run;
  end

  assign running_o = run;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~LIVE) == '0); // R10
  AST_EOQ_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[EOQ_BIT]) |-> !running_o); // R4
  AST_EOQ_MASTER_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[EOQ_BIT]) |-> $past(!slave_mode_i && last_bit_i)); // R3
  AST_TFUF_SLAVE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[TFUF_BIT]) |-> $past(slave_mode_i && txf_empty_i)); // R6
  AST_TFFF_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txf_full_i |=> rd_data_o[TFFF_BIT]); // R7
  AST_RFOF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[RFOF_BIT]) |-> $past(rxf_full_i && shreg_full_i)); // R8
endmodule

// File: tb/spi_qstat_reg_bench.sv
module spi_qstat_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        last_bit = 0, eoq_cmd = 0, slave = 0, xs = 0, tfull = 0, tempty = 0;
  logic        rfull = 0, shfull = 0, dma = 0, start = 0, stop = 0;
  logic        running;

  int checks = 0;
  int errors = 0;

  // model state
  logic m_tcf = 0, m_eoq = 0, m_tfuf = 0, m_tfff = 0, m_rfof = 0, m_run = 0;

  always #4 clk = ~clk;

  spi_qstat_reg u_spi_qstat_reg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .last_bit_i(last_bit), .eoq_cmd_i(eoq_cmd),
    .slave_mode_i(slave), .xfer_start_i(xs), .txf_full_i(tfull),
    .txf_empty_i(tempty), .rxf_full_i(rfull), .shreg_full_i(shfull),
    .dma_ack_i(dma), .start_i(start), .stop_i(stop), .running_o(running)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [10:0] v, input logic we, input logic [31:0] wd);
    {stop, start, dma, shfull, rfull, tempty, tfull, xs, slave, eoq_cmd, last_bit} = v;
    wr_en = we;
    wr_data = wd;
  endtask

  // next model state from the requirements, using held inputs
  task automatic model_step();
    logic eoq_set;
    logic [31:0] c;
    c = wr_en ? wr_data : 32'h0;
    eoq_set = last_bit & eoq_cmd & ~slave;
    m_tcf  = last_bit | (m_tcf & ~c[0]);
    m_eoq  = eoq_set | (m_eoq & ~c[3]);
    m_tfuf = (xs & slave & tempty) | (m_tfuf & ~c[4]);
    m_rfof = (xs & rfull & shfull) | (m_rfof & ~c[12]);
    m_tfff = ~tfull | (m_tfff & ~c[6] & ~dma);
    if (eoq_set || stop) m_run = 1'b0;
    else if (start)      m_run = 1'b1;
  endtask

  task automatic compare();
    check("R2 transfer-done bit0", {31'b0, rd_data[0]}, {31'b0, m_tcf});
    check("R3/R4 queue-end bit3", {31'b0, rd_data[3]}, {31'b0, m_eoq});
    check("R5 running bit1", {31'b0, rd_data[1]}, {31'b0, m_run});
    check("R5 running_o", {31'b0, running}, {31'b0, m_run});
    check("R6 underflow bit4", {31'b0, rd_data[4]}, {31'b0, m_tfuf});
    check("R7 tx room bit6", {31'b0, rd_data[6]}, {31'b0, m_tfff});
    check("R8 rx overflow bit12", {31'b0, rd_data[12]}, {31'b0, m_rfof});
    check("R10 reserved bits", rd_data & ~32'h0000_105B, 32'h0);
  endtask

  task automatic step(input logic [10:0] v, input logic we, input logic [31:0] wd);
    set_in(v, we, wd);
    @(posedge clk);
    @(negedge clk);
    model_step();
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'hACE1_1234;
    repeat (3) @(negedge clk);
    check("R1 reset rd_data", rd_data, 32'h0);
    check("R1 reset running", {31'b0, running}, 32'h0);
    rst_n = 1'b1;

    // sweep every event combination, with and without write
    for (int i = 0; i < 4096; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(i[10:0], i[11], lfsr);
    end

    // R9: set and clear together on transfer-done
    step(11'h001, 1'b1, 32'hFFFF_FFFF);
    check("R9 set wins bit0", {31'b0, rd_data[0]}, 32'h1);
    // R11: writing 0 does not clear, idle holds
    step(11'h000, 1'b1, 32'h0000_0000);
    check("R11 zero write keeps bit0", {31'b0, rd_data[0]}, 32'h1);
    step(11'h000, 1'b0, 32'h0);
    check("R11 idle keeps bit0", {31'b0, rd_data[0]}, 32'h1);
    // R4: queue-end with start in same cycle stops
    step(11'h200, 1'b0, 32'h0);
    check("R5 start runs", {31'b0, running}, 32'h1);
    step(11'h203, 1'b0, 32'h0);
    check("R4 queue-end beats start", {31'b0, running}, 32'h0);
    // R3: slave mode never sets queue-end
    step(11'h000, 1'b1, 32'h0000_0008);
    step(11'h007, 1'b0, 32'h0);
    check("R3 no queue-end in slave", {31'b0, rd_data[3]}, 32'h0);
    // R7: dma ack while not full keeps room flag
    step(11'h100, 1'b0, 32'h0);
    check("R7 dma when not full", {31'b0, rd_data[6]}, 32'h1);
    step(11'h110, 1'b0, 32'h0);
    check("R7 dma when full clears", {31'b0, rd_data[6]}, 32'h0);
    // R10: write ones to reserved bits
    step(11'h010, 1'b1, 32'hFFFF_EFA4);
    check("R10 reserved after write", rd_data & ~32'h0000_105B, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule